// File: doc/BRIEF.md
# Telephone Dial Sequencer

This block turns decoded keypad events into the actions a telephone dialer performs on the line. In pulse dialing it opens the loop by pulling a line-break output low once per pulse. In tone dialing it raises a tone-enable output together with a row index and a column index, which a separate two-tone synthesizer turns into sound. Every digit entered by hand is also kept in a small memory, so one key press can replay the whole number later. The flash, pause and mute keys are handled here as well.

The options are set by four strap inputs. They are sampled once, at the moment the hook input rises (the handset goes off-hook), and are held until the next off-hook. Keys that arrive while a digit, a replay, a flash or a pause is still running are held in a short queue and carried out in arrival order. All timing is counted in milliseconds from a prescaler on the single system clock, which is nominally 3.58 MHz.

Top module: `dial_sequencer`

## Requirements
- R1: At the cycle `hook_i` rises, `strap_i` is latched: bit 0 = 1 selects pulse dialing (0 = tone), bit 1 = 1 selects 20 pulses/s (0 = 10), bit 2 = 1 selects a 67 % break share (0 = 60 %), bit 3 = 1 selects a 160 ms tone gap (0 = 82 ms). Later strap changes have no effect until the next off-hook.
- R2: Key codes 0 to 9 are digits. In pulse mode digit N drives `line_brk_n_o` low N times, and digit 0 drives it low 10 times.
- R3: The break and make lengths of each pulse are 60/40 ms or 67/33 ms at 10 pulses/s, and 30/20 ms or 33/17 ms at 20 pulses/s.
- R4: After the last break of a pulse digit, the line stays made for 800 ms before the next action starts.
- R5: In tone mode each digit raises `tone_en_o` with `tone_row_o` and `tone_col_o` set as follows. Keys 1 to 9 give row (k-1)/3 and column (k-1)%3. Key 0 gives row 3, column 1. `*` (code 10) gives row 3, column 0. `#` (code 11) gives row 3, column 2.
- R6: A hand-dialled tone lasts at least 82 ms. If the key is still held and no other key is waiting, the tone continues until the key is released. Every tone is followed by the selected silent gap.
- R7: A replayed tone lasts exactly 82 ms, followed by the selected gap.
- R8: The first dialable key entered by hand after an off-hook empties the memory before it is stored. At most 32 digits are kept, and any further ones are dropped. Redial (code 15) replays the stored digits in order. With an empty memory, redial does nothing.
- R9: Flash (code 14) holds `line_brk_n_o` low for 300 ms when `flash_opt_i` is 0 and for 600 ms when it is 1.
- R10: Pause (code 12) raises `mic_mute_o` for 2200 ms. No dialing takes place during that time.
- R11: Mute (code 13) toggles `mic_mute_o` on the next cycle, at every press, and bypasses the queue.
- R12: Keys that arrive while the sequencer is busy are queued, up to 4 entries, and are executed in order. Keys that arrive while the queue is full are dropped.
- R13: After reset, and while `hook_i` is low: `line_brk_n_o` is high, `tone_en_o` and `mic_mute_o` are low, keys are ignored and the queue is emptied. The redial memory is kept.
- R14: In pulse mode, `*` and `#` are discarded. They are neither dialed nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hook_i | input | 1 | High while off-hook |
| strap_i | input | 4 | Option straps, latched at off-hook |
| flash_opt_i | input | 1 | Flash length select |
| key_stb_i | input | 1 | One-cycle strobe for a new key |
| key_code_i | input | 4 | Code of the strobed key |
| key_held_i | input | 1 | High while the last key is still pressed |
| line_brk_n_o | output | 1 | Low while the loop is broken |
| tone_en_o | output | 1 | High while a tone pair should sound |
| tone_row_o | output | 2 | Low-group frequency index |
| tone_col_o | output | 2 | High-group frequency index |
| mic_mute_o | output | 1 | High while the microphone is inhibited |

## Verification
The bench checks digit 0, because a design that counted it as zero pulses would leave a digit out of the number. It checks the 800 ms inter-digit make, because a design that skipped it would run two digits together into one. It fills the memory past 32 digits and replays it after a fresh off-hook, which catches a design that wraps around and overwrites the first digits, and one that never clears the memory on the first manual digit. It also queues more keys than the queue can hold, presses `*` in pulse mode and changes the straps in the middle of a call. A design that overflowed the queue, dialed the star key or followed live straps would put a wrong pulse count on the line.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_BRK,
      S_MAKE,
      S_IDP,
      S_TONE,
      S_HOLD,
      S_GAP,
      S_FLASH,
      S_PAUSE
   } seq_st_t;

   typedef struct packed {
      logic pulse;
      logic fast;
      logic steep;
      logic long_gap;
   } dial_opt_t;

   localparam logic [3:0] KC_STAR   = 4'd10;
   localparam logic [3:0] KC_HASH   = 4'd11;
   localparam logic [3:0] KC_PAUSE  = 4'd12;
   localparam logic [3:0] KC_MUTE   = 4'd13;
   localparam logic [3:0] KC_FLASH  = 4'd14;
   localparam logic [3:0] KC_REDIAL = 4'd15;

   function automatic logic [1:0] key_row(input logic [3:0] kc);
      logic [3:0] t;
      if (kc == 4'd0 || kc > 4'd9) return 2'd3;
      t = (kc - 4'd1) / 4'd3;
      return t[1:0];
   endfunction

   function automatic logic [1:0] key_col(input logic [3:0] kc);
      logic [3:0] t;
      if (kc == 4'd0)    return 2'd1;
      if (kc == KC_STAR) return 2'd0;
      if (kc == KC_HASH) return 2'd2;
      t = (kc - 4'd1) % 4'd3;
      return t[1:0];
   endfunction

endpackage

// File: rtl/dsq_timer.sv
module dsq_timer #(
   parameter int DIV = 3580,
   parameter int MSW = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [MSW-1:0] ms_val,
   output logic           expire
);
   logic [MSW-1:0] left;

   initial begin : p_chk
      assert (DIV >= 1) else $error("DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_nopre
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          left <= '0;
            else if (load)       left <= ms_val;
            else if (left != 0)  left <= left - 1'b1;
         end
         assign expire = (left == MSW'(1));
      end else begin : g_pre
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] PMAX = PW'(DIV - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left <= '0;
               pre  <= '0;
            end else if (load) begin
               left <= ms_val;
               pre  <= '0;
            end else if (left != 0) begin
               if (pre == PMAX) begin
                  pre  <= '0;
                  left <= left - 1'b1;
               end else begin
                  pre <= pre + 1'b1;
               end
            end
         end
         assign expire = (left == MSW'(1)) && (pre == PMAX);
      end
   endgenerate

   AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ms_val > MSW'(1)) |=> !expire); // R3

endmodule

// File: rtl/dsq_keyq.sv
module dsq_keyq #(
   parameter int DEPTH = 4,
   parameter int W     = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  slot [DEPTH];
   logic [AW-1:0] rp, wp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   initial begin : p_chk
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("queue depth must be a power of two, at least 2");
   end

   assign empty   = (cnt == 0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slot[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) slot[wp] <= din;
   end

   AST_Q_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full); // R12
   AST_Q_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R13

endmodule

// File: rtl/dsq_redial.sv
module dsq_redial #(
   parameter int DEPTH = 32,
   parameter int W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic                       restart,
   input  logic [W-1:0]               din,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH):0]     cnt
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];

   initial begin : p_chk
      assert (DEPTH >= 2) else $error("redial depth must be at least 2");
   end

   assign rdata = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (wr && restart)                    cnt <= (AW+1)'(1);
      else if (wr && cnt < (AW+1)'(DEPTH))       cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr && restart)                         mem[0] <= din;
      else if (wr && cnt < (AW+1)'(DEPTH))       mem[cnt[AW-1:0]] <= din;
   end

   AST_MEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH)); // R8
   AST_MEM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && restart) |=> (cnt == (AW+1)'(1))); // R8

endmodule

// File: rtl/dial_sequencer.sv
module dial_sequencer
   import dsq_pkg::*;
#(
   parameter int CLK_HZ         = 3_580_000,
   parameter int MSW            = 12,
   parameter int QDEPTH         = 4,
   parameter int MEM_DEPTH      = 32,
   parameter int TONE_MS        = 82,
   parameter int GAP_SHORT_MS   = 82,
   parameter int GAP_LONG_MS    = 160,
   parameter int FLASH_SHORT_MS = 300,
   parameter int FLASH_LONG_MS  = 600,
   parameter int PAUSE_MS       = 2200,
   parameter int IDP_MS         = 800,
   parameter int PER_SLOW_MS    = 100,
   parameter int PER_FAST_MS    = 50,
   parameter int BRK_PCT_STD    = 60,
   parameter int BRK_PCT_STEEP  = 67
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hook_i,
   input  logic [3:0] strap_i,
   input  logic       flash_opt_i,
   input  logic       key_stb_i,
   input  logic [3:0] key_code_i,
   input  logic       key_held_i,
   output logic       line_brk_n_o,
   output logic       tone_en_o,
   output logic [1:0] tone_row_o,
   output logic [1:0] tone_col_o,
   output logic       mic_mute_o
);
   localparam int TICK_DIV   = CLK_HZ / 1000;
   localparam int AW         = $clog2(MEM_DEPTH);
   localparam int BRK_SL_STD = PER_SLOW_MS * BRK_PCT_STD / 100;
   localparam int BRK_SL_STP = PER_SLOW_MS * BRK_PCT_STEEP / 100;
   localparam int BRK_FA_STD = PER_FAST_MS * BRK_PCT_STD / 100;
   localparam int BRK_FA_STP = PER_FAST_MS * BRK_PCT_STEEP / 100;
   localparam int MK_SL_STD  = PER_SLOW_MS - BRK_SL_STD;
   localparam int MK_SL_STP  = PER_SLOW_MS - BRK_SL_STP;
   localparam int MK_FA_STD  = PER_FAST_MS - BRK_FA_STD;
   localparam int MK_FA_STP  = PER_FAST_MS - BRK_FA_STP;

   initial begin : p_chk
      assert (TICK_DIV >= 1) else $error("clock below 1 kHz");
      assert (PAUSE_MS < (1 << MSW) && IDP_MS < (1 << MSW) && FLASH_LONG_MS < (1 << MSW))
         else $error("MSW too narrow for the timing parameters");
      assert (MK_SL_STP > 0 && MK_FA_STP > 0) else $error("make interval must be non-zero");
   end

   seq_st_t        st, nxt;
   dial_opt_t      opt;
   logic           hook_q, mute_q, replay, recorded;
   logic [AW:0]    rp_idx;
   logic [3:0]     pulse_left, cur_code;
   logic           cur_manual;

   logic           key_ok, q_push, q_pop, q_empty, q_full;
   logic [3:0]     q_dout;
   logic           mem_wr;
   logic [3:0]     mem_rdata;
   logic [AW:0]    mem_cnt;
   logic           tm_load, tm_exp;
   logic [MSW-1:0] tm_ms, brk_ms, mk_ms, gap_ms, flash_ms;
   logic           start, start_manual, rp_inc, replay_set, replay_clr;
   logic [3:0]     start_code;

   // ---------------- sub-blocks ----------------
   dsq_keyq #(.DEPTH(QDEPTH), .W(4)) u_keyq (
      .clk(clk), .rst_n(rst_n), .flush(!hook_i),
      .push(q_push), .din(key_code_i), .pop(q_pop),
      .dout(q_dout), .empty(q_empty), .full(q_full)
   );

   dsq_redial #(.DEPTH(MEM_DEPTH), .W(4)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr(mem_wr), .restart(!recorded),
      .din(q_dout), .rd_idx(rp_idx[AW-1:0]), .rdata(mem_rdata), .cnt(mem_cnt)
   );

   dsq_timer #(.DIV(TICK_DIV), .MSW(MSW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tm_load), .ms_val(tm_ms), .expire(tm_exp)
   );

   // ---------------- option-derived intervals ----------------
   always_comb begin
      unique case ({opt.fast, opt.steep})
         2'b00:   begin brk_ms = MSW'(BRK_SL_STD); mk_ms = MSW'(MK_SL_STD); end
         2'b01:   begin brk_ms = MSW'(BRK_SL_STP); mk_ms = MSW'(MK_SL_STP); end
         2'b10:   begin brk_ms = MSW'(BRK_FA_STD); mk_ms = MSW'(MK_FA_STD); end
         default: begin brk_ms = MSW'(BRK_FA_STP); mk_ms = MSW'(MK_FA_STP); end
      endcase
      gap_ms   = opt.long_gap ? MSW'(GAP_LONG_MS) : MSW'(GAP_SHORT_MS);
      flash_ms = flash_opt_i ? MSW'(FLASH_LONG_MS) : MSW'(FLASH_SHORT_MS);
   end

   assign key_ok = key_stb_i && hook_i && hook_q;
   assign q_push = key_ok && (key_code_i != KC_MUTE);

   // ---------------- sequencing ----------------
   always_comb begin
      nxt          = st;
      tm_load      = 1'b0;
      tm_ms        = '0;
      q_pop        = 1'b0;
      mem_wr       = 1'b0;
      start        = 1'b0;
      start_code   = q_dout;
      start_manual = 1'b0;
      rp_inc       = 1'b0;
      replay_set   = 1'b0;
      replay_clr   = 1'b0;
      if (hook_i && hook_q) begin
         unique case (st)
            S_IDLE: begin
               if (replay) begin
                  if (rp_idx < mem_cnt) begin
                     rp_inc = 1'b1;
                     if (!(opt.pulse && mem_rdata > 4'd9)) begin
                        start      = 1'b1;
                        start_code = mem_rdata;
                     end
                  end else begin
                     replay_clr = 1'b1;
                  end
               end else if (!q_empty) begin
                  q_pop = 1'b1;
                  unique case (q_dout)
                     KC_PAUSE: begin nxt = S_PAUSE; tm_load = 1'b1; tm_ms = MSW'(PAUSE_MS); end
                     KC_FLASH: begin nxt = S_FLASH; tm_load = 1'b1; tm_ms = flash_ms; end
                     KC_REDIAL: replay_set = (mem_cnt != 0);
                     KC_MUTE:   ;
                     default: begin
                        if (!(opt.pulse && q_dout > 4'd9)) begin
                           start        = 1'b1;
                           start_manual = 1'b1;
                           mem_wr       = 1'b1;
                        end
                     end
                  endcase
               end
               if (start) begin
                  tm_load = 1'b1;
                  if (opt.pulse) begin nxt = S_BRK;  tm_ms = brk_ms; end
                  else           begin nxt = S_TONE; tm_ms = MSW'(TONE_MS); end
               end
            end
            S_BRK: if (tm_exp) begin
               tm_load = 1'b1;
               if (pulse_left == 4'd1) begin nxt = S_IDP;  tm_ms = MSW'(IDP_MS); end
               else                    begin nxt = S_MAKE; tm_ms = mk_ms; end
            end
            S_MAKE: if (tm_exp) begin
               nxt = S_BRK; tm_load = 1'b1; tm_ms = brk_ms;
            end
            S_TONE: if (tm_exp) begin
               if (cur_manual && key_held_i && q_empty) nxt = S_HOLD;
               else begin nxt = S_GAP; tm_load = 1'b1; tm_ms = gap_ms; end
            end
            S_HOLD: if (!key_held_i || !q_empty) begin
               nxt = S_GAP; tm_load = 1'b1; tm_ms = gap_ms;
            end
            S_IDP, S_GAP, S_FLASH, S_PAUSE: if (tm_exp) nxt = S_IDLE;
            default: nxt = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         hook_q     <= 1'b0;
         opt        <= '0;
         mute_q     <= 1'b0;
         replay     <= 1'b0;
         recorded   <= 1'b0;
         rp_idx     <= '0;
         pulse_left <= '0;
         cur_code   <= '0;
         cur_manual <= 1'b0;
      end else begin
         hook_q <= hook_i;
         if (!hook_i) begin
            st       <= S_IDLE;
            mute_q   <= 1'b0;
            replay   <= 1'b0;
            recorded <= 1'b0;
         end else begin
            st <= nxt;
            if (!hook_q) begin
               opt.pulse    <= strap_i[0];
               opt.fast     <= strap_i[1];
               opt.steep    <= strap_i[2];
               opt.long_gap <= strap_i[3];
            end
            if (key_ok && key_code_i == KC_MUTE) mute_q <= !mute_q;
            if (mem_wr) recorded <= 1'b1;
            if (replay_set) begin
               replay <= 1'b1;
               rp_idx <= '0;
            end else begin
               if (replay_clr) replay <= 1'b0;
               if (rp_inc)     rp_idx <= rp_idx + 1'b1;
            end
            if (start) begin
               cur_code   <= start_code;
               cur_manual <= start_manual;
               pulse_left <= (start_code == 4'd0) ? 4'd10 : start_code;
            end else if (st == S_BRK && tm_exp) begin
               pulse_left <= pulse_left - 1'b1;
            end
         end
      end
   end

   // ---------------- outputs ----------------
   assign line_brk_n_o = !(st == S_BRK || st == S_FLASH);
   assign tone_en_o    = (st == S_TONE || st == S_HOLD);
   assign tone_row_o   = key_row(cur_code);
   assign tone_col_o   = key_col(cur_code);
   assign mic_mute_o   = mute_q || (st == S_PAUSE);

   // ---------------- checks ----------------
   AST_ONHOOK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hook_i |=> (line_brk_n_o && !tone_en_o && !mic_mute_o)); // R13
   AST_TONE_ONLY_DTMF: assert property (@(posedge clk) disable iff (!rst_n)
      tone_en_o |-> !opt.pulse); // R5
   AST_TONE_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tone_en_o |-> (tone_col_o != 2'd3)); // R5
   AST_BREAK_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BRK) |-> (opt.pulse && pulse_left >= 4'd1 && pulse_left <= 4'd10)); // R2
   AST_MUTE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (key_ok && key_code_i == KC_MUTE) |=> (mute_q != $past(mute_q))); // R11
   AST_PAUSE_NO_DIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PAUSE) |-> (line_brk_n_o && !tone_en_o)); // R10

endmodule

// File: tb/dial_sequencer_bench.sv
module dial_sequencer_bench;
   localparam int DIV = 2;
   localparam int TOL = 3;

   logic clk = 1'b0, rst_n = 1'b0, hook = 1'b0, fopt = 1'b0;
   logic key_stb = 1'b0, key_held = 1'b0;
   logic [3:0] strap = 4'd0, key_code = 4'd0;
   logic brk_n, tone_en, mute;
   logic [1:0] trow_o, tcol_o;

   always #10 clk = !clk;

   dial_sequencer #(.CLK_HZ(DIV * 1000)) u_dial_sequencer (
      .clk(clk), .rst_n(rst_n), .hook_i(hook), .strap_i(strap), .flash_opt_i(fopt),
      .key_stb_i(key_stb), .key_code_i(key_code), .key_held_i(key_held),
      .line_brk_n_o(brk_n), .tone_en_o(tone_en), .tone_row_o(trow_o),
      .tone_col_o(tcol_o), .mic_mute_o(mute)
   );

   int nvec = 0, nerr = 0, cyc = 0;
   int bs[256], be[256], nb = 0;
   int ts[64], te[64], tr[64], tc[64], nt = 0;
   int mu_s = 0, mu_e = 0, nmu = 0;
   logic pl = 1'b1, pt = 1'b0, pm = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (pl && !brk_n && nb < 256) bs[nb] = cyc;
      if (!pl && brk_n && nb < 256) begin be[nb] = cyc; nb++; end
      if (!pt && tone_en && nt < 64) begin ts[nt] = cyc; tr[nt] = trow_o; tc[nt] = tcol_o; end
      if (pt && !tone_en && nt < 64) begin te[nt] = cyc; nt++; end
      if (!pm && mute && nmu == 0) mu_s = cyc;
      if (pm && !mute && nmu == 0) begin mu_e = cyc; nmu++; end
      pl = brk_n; pt = tone_en; pm = mute;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic bit near(input int a, input int e);
      return (a >= e - TOL) && (a <= e + TOL);
   endfunction

   function automatic int erow(input int k);
      case (k)
         1, 2, 3: return 0;
         4, 5, 6: return 1;
         7, 8, 9: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic int ecol(input int k);
      case (k)
         10, 1, 4, 7: return 0;
         0, 2, 5, 8:  return 1;
         default:     return 2;
      endcase
   endfunction

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask
   task automatic wms(input int n); tick(n * DIV); endtask
   task automatic clr(); nb = 0; nt = 0; nmu = 0; endtask

   task automatic press(input int k);
      @(negedge clk); key_stb = 1'b1; key_code = k[3:0];
      @(negedge clk); key_stb = 1'b0;
   endtask

   task automatic go_on(); hook = 1'b0; tick(4); endtask
   task automatic go_off(input logic [3:0] s, input logic f);
      hook = 1'b0; tick(4); strap = s; fopt = f; hook = 1'b1; tick(4); clr();
   endtask

   task automatic chk_train(input int dg[8], input int nd, input int brk, input int mk, input string rq);
      int tot = 0, k = 0;
      for (int i = 0; i < nd; i++) tot += (dg[i] == 0) ? 10 : dg[i];
      chk(nb == tot, {rq, " pulse count"}, nb, tot);
      if (nb != tot) return;
      for (int i = 0; i < nd; i++) begin
         int np = (dg[i] == 0) ? 10 : dg[i];
         for (int p = 0; p < np; p++) begin
            chk(near(be[k] - bs[k], brk * DIV), {rq, " break length"}, be[k] - bs[k], brk * DIV);
            if (p < np - 1)
               chk(near(bs[k+1] - be[k], mk * DIV), {rq, " make length"}, bs[k+1] - be[k], mk * DIV);
            else if (i < nd - 1)
               chk(near(bs[k+1] - be[k], 800 * DIV), "R4 inter-digit make", bs[k+1] - be[k], 800 * DIV);
            k++;
         end
      end
   endtask

   task automatic chk_tones(input int dg[40], input int nd, input int ton, input int gap, input string rq);
      chk(nt == nd, {rq, " tone count"}, nt, nd);
      if (nt != nd) return;
      for (int i = 0; i < nd; i++) begin
         chk(tr[i] == erow(dg[i]), "R5 row index", tr[i], erow(dg[i]));
         chk(tc[i] == ecol(dg[i]), "R5 column index", tc[i], ecol(dg[i]));
         chk(near(te[i] - ts[i], ton * DIV), {rq, " tone length"}, te[i] - ts[i], ton * DIV);
         if (i < nd - 1)
            chk(near(ts[i+1] - te[i], gap * DIV), {rq, " gap length"}, ts[i+1] - te[i], gap * DIV);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin : main
      int dg[8];
      int mem[40];
      int ex[40];
      int d;
      void'($urandom(32'd7101));

      // reset state R13
      tick(5);
      chk(brk_n == 1'b1 && tone_en == 1'b0 && mute == 1'b0, "R13 reset outputs", {brk_n, tone_en, mute}, 3'b100);
      rst_n = 1'b1; tick(3);

      // R8 empty memory redial
      go_off(4'b0000, 1'b0);
      press(15); wms(100);
      chk(nt == 0, "R8 redial with empty memory", nt, 0);

      // R5 R6 manual tones with short gap, queued back to back
      clr();
      for (int i = 0; i < 3; i++) begin mem[i] = $urandom % 12; press(mem[i]); end
      wms(3 * 164 + 50);
      chk_tones(mem, 3, 82, 82, "R6");

      // R6 held key extends tone
      clr();
      mem[3] = 4;
      @(negedge clk); key_stb = 1'b1; key_code = 4'd4; key_held = 1'b1;
      @(negedge clk); key_stb = 1'b0;
      tick(200 * DIV - 1); key_held = 1'b0;
      wms(150);
      chk(nt == 1 && te[0] - ts[0] >= 200 * DIV - TOL && te[0] - ts[0] <= 200 * DIV + TOL,
          "R6 held tone length", te[0] - ts[0], 200 * DIV);

      // R11 mute toggling
      press(13); tick(2);
      chk(mute == 1'b1, "R11 mute on", mute, 1);
      press(13); tick(2);
      chk(mute == 1'b0, "R11 mute off", mute, 0);
      press(13); tick(2); go_on();
      chk(mute == 1'b0, "R13 mute cleared on-hook", mute, 0);

      // R7 R8 R1 replay with long gap after new off-hook
      go_off(4'b1000, 1'b0);
      press(15); wms(4 * 242 + 60);
      chk_tones(mem, 4, 82, 160, "R7");

      // R10 pause then digit
      clr();
      press(12); press(5);
      wms(2200 + 300);
      chk(nmu == 1 && near(mu_e - mu_s, 2200 * DIV), "R10 pause mute length", mu_e - mu_s, 2200 * DIV);
      chk(nt == 1 && ts[0] >= mu_e - TOL, "R10 no dialing during pause", ts[0], mu_e);

      // R9 flash lengths
      go_off(4'b0000, 1'b0);
      press(14); wms(350);
      chk(nb == 1 && near(be[0] - bs[0], 300 * DIV), "R9 short flash", be[0] - bs[0], 300 * DIV);
      clr(); fopt = 1'b1;
      press(14); wms(650);
      chk(nb == 1 && near(be[0] - bs[0], 600 * DIV), "R9 long flash", be[0] - bs[0], 600 * DIV);

      // R1 R2 R3 R4 pulse 10 pps 60/40, straps changed after off-hook
      go_off(4'b0001, 1'b0);
      strap = 4'b1110;
      press(3); press(0);
      wms(1300 + 1600 + 100);
      dg[0] = 3; dg[1] = 0;
      chk_train(dg, 2, 60, 40, "R2 R1");

      // R3 20 pps 67 percent, random digit
      go_off(4'b0111, 1'b0);
      d = 1 + $urandom % 9;
      press(d); wms(d * 50 + 900);
      dg[0] = d;
      chk_train(dg, 1, 33, 17, "R3");

      // R14 star dropped in pulse mode
      clr();
      press(10); press(2); wms(100 + 900);
      dg[0] = 2;
      chk_train(dg, 1, 33, 17, "R14");

      // R12 queue overflow drops late keys
      clr();
      for (int i = 0; i < 5; i++) press(1);
      press(2); press(2);
      wms(5 * 850 + 300);
      for (int i = 0; i < 5; i++) dg[i] = 1;
      chk_train(dg, 5, 33, 17, "R12");

      // R8 memory limit of 32 digits
      go_off(4'b0000, 1'b0);
      for (int i = 0; i < 35; i++) begin ex[i] = $urandom % 12; press(ex[i]); wms(180); end
      chk(nt == 35, "R8 manual tones dialed", nt, 35);
      go_on(); go_off(4'b0000, 1'b0);
      press(15); wms(32 * 164 + 100);
      chk_tones(ex, 32, 82, 82, "R8");

      // R8 first manual digit clears memory
      press(7); wms(200);
      go_on(); go_off(4'b0000, 1'b0);
      press(15); wms(250);
      chk(nt == 1 && tr[0] == 2 && tc[0] == 0, "R8 memory cleared by first digit", nt, 1);

      // R13 keys ignored on-hook
      go_on(); clr();
      press(5); press(14); wms(200);
      chk(nb == 0 && nt == 0 && brk_n == 1'b1, "R13 on-hook keys ignored", nb + nt, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule